// File: doc/BRIEF.md
# Serial Clock-Configuration Register Receiver

This block takes a 24-bit configuration word on a three-wire serial link (a serial clock, a data line and a load strobe) and holds it in a latch whose fields drive a programmable clock generator. The fields are a crystal load-capacitance select, a duty-cycle reference mode, a second-output source select, an output-divider code, a 9-bit feedback divider word and a 7-bit reference divider word. Bits are shifted in most significant bit first on each rising edge of the serial clock. A high strobe copies the shift register into the latch. While the strobe stays high, the latch follows the shift register bit by bit, so the outputs change as data is clocked.

The three serial inputs are brought into the system clock domain through a synchronizer, and edges are detected there. After reset the latch holds a fixed default word that gives a unity input-to-output frequency ratio. The decoded outputs also include the actual output division factor, a flag for a forbidden feedback word, and a flag for the reference-bypass condition. A further flag reports that the most recent strobe arrived after a number of serial clock edges other than 24.

Top module: `serial_cfg_rx`

## Requirements
- R1: After reset the latch holds 24'h230406: cap_sel 00, duty_mode 1, aux_sel 00, odiv_code 3'b011 (odiv_value 4), fb_word 8, ref_word 6, and fb_illegal, pll_bypass and load_short are all 0.
- R2: Each rising edge of ser_clk shifts ser_data into bit 0 of the 24-bit shift register and moves the older bits up by one. The first bit of a word therefore lands in bit 23.
- R3: Latched bit positions: bits 23:22 are cap_sel, bit 21 is duty_mode, bits 20:19 are aux_sel, bits 18:16 are odiv_code, bits 15:7 are fb_word and bits 6:0 are ref_word.
- R4: While ser_load is low, the latch and all field outputs keep their values, whatever ser_clk and ser_data do.
- R5: While ser_load is high, the latch copies the shift register every cycle. Each ser_clk rising edge during that time therefore shows up at the outputs.
- R6: odiv_value follows odiv_code as 000→10, 001→2, 010→8, 011→4, 100→5, 101→7, 110→3, 111→6.
- R7: fb_illegal is 1 exactly when the latched fb_word is below 4.
- R8: pll_bypass is 1 exactly when the latched ref_word is 0.
- R9: At each rising edge of ser_load, load_short is set if the number of ser_clk rising edges since the previous rising edge of ser_load (or since reset) is not 24, and cleared if it is 24. The edge count saturates rather than wrapping. load_short holds its value between ser_load rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a high level makes the latch follow the shift register |
| cap_sel | output | 2 | Crystal load-capacitance select |
| duty_mode | output | 1 | Duty-cycle reference mode |
| aux_sel | output | 2 | Second-output source select |
| odiv_code | output | 3 | Output-divider select code |
| odiv_value | output | 4 | Decoded output division factor |
| fb_word | output | 9 | Feedback divider word |
| ref_word | output | 7 | Reference divider word |
| fb_illegal | output | 1 | Latched feedback word is below 4 |
| pll_bypass | output | 1 | Latched reference word is 0 |
| load_short | output | 1 | Last strobe came after a count of serial edges other than 24 |

## Verification
The bench sends words with the strobe low and checks that the outputs stay frozen until the strobe pulse. A design that leaks shift data into the latch fails at that point. It also clocks bits with the strobe held high and checks after every bit that the outputs step with the shift register; a latch that only loads on the strobe edge would stay stale there. Partial and overlong bursts (20, 23, 25 and 30 bits) catch a bit counter that is off by one, that wraps, or that is not cleared at the strobe. Feedback words 0 to 4 and reference words 0 and 1 are forced to probe the edges of both flags, and every output-divider code is walked to catch a wrong decode entry.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int CAP_W  = 2;
  localparam int AUX_W  = 2;
  localparam int ODC_W  = 3;
  localparam int FB_W   = 9;
  localparam int REF_W  = 7;
  localparam int ODV_W  = 4;
  localparam int WORD_W = CAP_W + 1 + AUX_W + ODC_W + FB_W + REF_W;

  localparam int FB_MIN = 4;

  typedef struct packed {
    logic [CAP_W-1:0] cap;
    logic             duty;
    logic [AUX_W-1:0] aux;
    logic [ODC_W-1:0] odc;
    logic [FB_W-1:0]  fb;
    logic [REF_W-1:0] rf;
  } cfg_word_t;

  localparam logic [WORD_W-1:0] CFG_DEFAULT = 24'h230406;

  function automatic logic [ODV_W-1:0] od_factor(input logic [ODC_W-1:0] code);
    logic [ODV_W-1:0] f;
    case (code)
      3'd0:    f = 4'd10;
      3'd1:    f = 4'd2;
      3'd2:    f = 4'd8;
      3'd3:    f = 4'd4;
      3'd4:    f = 4'd5;
      3'd5:    f = 4'd7;
      3'd6:    f = 4'd3;
      default: f = 4'd6;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
  parameter int STAGES = 2,
  parameter int BITS   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d_in,
  output logic [BITS-1:0] d_out
);

  genvar b;
  generate
    for (b = 0; b < BITS; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in[b]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign d_out[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift
  import serial_cfg_pkg::*;
#(
  parameter int CNT_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              data_s,
  input  logic              strb_s,
  output logic [WORD_W-1:0] shift_q,
  output logic              sclk_rise,
  output logic              strb_rise,
  output logic              short_q
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic              sclk_d1_q;
  logic              strb_d1_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shift_d;
  logic              short_d;
  logic              cnt_en;

  assign sclk_rise = sclk_s & ~sclk_d1_q;
  assign strb_rise = strb_s & ~strb_d1_q;

  always_comb begin
    shift_d = shift_q;
    if (sclk_rise) shift_d = {shift_q[WORD_W-2:0], data_s};
  end

  always_comb begin
    cnt_en  = strb_rise | (sclk_rise & (cnt_q != CNT_MAX));
    cnt_d   = cnt_q;
    short_d = short_q;
    if (strb_rise) begin
      short_d = (cnt_q != CNT_FULL);
      cnt_d   = '0;
    end else if (sclk_rise && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d1_q <= 1'b0;
      strb_d1_q <= 1'b0;
    end else begin
      sclk_d1_q <= sclk_s;
      strb_d1_q <= strb_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shift_q <= CFG_DEFAULT;
    else if (sclk_rise) shift_q <= shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         short_q <= 1'b0;
    else if (strb_rise) short_q <= short_d;
  end

endmodule

// File: rtl/serial_cfg_latch.sv
module serial_cfg_latch
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_s,
  input  logic [WORD_W-1:0] shift_q,
  output cfg_word_t         hold_q
);

  cfg_word_t hold_d;

  always_comb begin
    hold_d = hold_q;
    if (strb_s) hold_d = cfg_word_t'(shift_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= cfg_word_t'(CFG_DEFAULT);
    else if (strb_s) hold_q <= hold_d;
  end

endmodule

// File: rtl/serial_cfg_decode.sv
module serial_cfg_decode
  import serial_cfg_pkg::*;
(
  input  cfg_word_t         word,
  output logic [CAP_W-1:0]  cap_sel,
  output logic              duty_mode,
  output logic [AUX_W-1:0]  aux_sel,
  output logic [ODC_W-1:0]  odiv_code,
  output logic [ODV_W-1:0]  odiv_value,
  output logic [FB_W-1:0]   fb_word,
  output logic [REF_W-1:0]  ref_word,
  output logic              fb_illegal,
  output logic              pll_bypass
);

  always_comb begin
    cap_sel    = word.cap;
    duty_mode  = word.duty;
    aux_sel    = word.aux;
    odiv_code  = word.odc;
    odiv_value = od_factor(word.odc);
    fb_word    = word.fb;
    ref_word   = word.rf;
    fb_illegal = (word.fb < FB_W'(FB_MIN));
    pll_bypass = (word.rf == '0);
  end

endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  output logic [1:0]       cap_sel,
  output logic             duty_mode,
  output logic [1:0]       aux_sel,
  output logic [2:0]       odiv_code,
  output logic [3:0]       odiv_value,
  output logic [8:0]       fb_word,
  output logic [6:0]       ref_word,
  output logic             fb_illegal,
  output logic             pll_bypass,
  output logic             load_short
);

  logic [2:0]        raw_in;
  logic [2:0]        sync_out;
  logic              sclk_s, data_s, strb_s;
  logic [WORD_W-1:0] shift_q;
  logic              sclk_rise, strb_rise;
  cfg_word_t         hold_q;

  assign raw_in = {ser_load, ser_data, ser_clk};
  assign sclk_s = sync_out[0];
  assign data_s = sync_out[1];
  assign strb_s = sync_out[2];

  serial_cfg_sync #(.STAGES(SYNC_STAGES), .BITS(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_in),
    .d_out (sync_out)
  );

  serial_cfg_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .data_s    (data_s),
    .strb_s    (strb_s),
    .shift_q   (shift_q),
    .sclk_rise (sclk_rise),
    .strb_rise (strb_rise),
    .short_q   (load_short)
  );

  serial_cfg_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb_s  (strb_s),
    .shift_q (shift_q),
    .hold_q  (hold_q)
  );

  serial_cfg_decode u_dec (
    .word       (hold_q),
    .cap_sel    (cap_sel),
    .duty_mode  (duty_mode),
    .aux_sel    (aux_sel),
    .odiv_code  (odiv_code),
    .odiv_value (odiv_value),
    .fb_word    (fb_word),
    .ref_word   (ref_word),
    .fb_illegal (fb_illegal),
    .pll_bypass (pll_bypass)
  );

endmodule

// File: rtl/serial_cfg_rx_chk.sv
module serial_cfg_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strb_s,
  input logic        data_s,
  input logic        sclk_rise,
  input logic        strb_rise,
  input logic [23:0] shift_q,
  input logic [1:0]  cap_sel,
  input logic        duty_mode,
  input logic [1:0]  aux_sel,
  input logic [2:0]  odiv_code,
  input logic [3:0]  odiv_value,
  input logic [8:0]  fb_word,
  input logic [6:0]  ref_word,
  input logic        fb_illegal,
  input logic        pll_bypass,
  input logic        load_short
);

  logic [23:0] out_word;
  assign out_word = {cap_sel, duty_mode, aux_sel, odiv_code, fb_word, ref_word};

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q == {$past(shift_q[22:0]), $past(data_s)});

  p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shift_q));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_s |=> $stable(out_word));

  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb_s |=> out_word == $past(shift_q));

  p_od_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    odiv_value >= 4'd2 && odiv_value <= 4'd10 && odiv_value != 4'd9);

  p_fb_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fb_illegal == (fb_word < 9'd4));

  p_bypass_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass == (ref_word == 7'd0));

  p_short_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_rise |=> $stable(load_short));

endmodule

bind serial_cfg_rx serial_cfg_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strb_s     (strb_s),
  .data_s     (data_s),
  .sclk_rise  (sclk_rise),
  .strb_rise  (strb_rise),
  .shift_q    (shift_q),
  .cap_sel    (cap_sel),
  .duty_mode  (duty_mode),
  .aux_sel    (aux_sel),
  .odiv_code  (odiv_code),
  .odiv_value (odiv_value),
  .fb_word    (fb_word),
  .ref_word   (ref_word),
  .fb_illegal (fb_illegal),
  .pll_bypass (pll_bypass),
  .load_short (load_short)
);

// File: tb/test_serial_cfg_rx.sv
module test_serial_cfg_rx;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 5;

  logic clk, rst_n, ser_clk, ser_data, ser_load;
  logic [1:0] cap_sel, aux_sel;
  logic       duty_mode, fb_illegal, pll_bypass, load_short;
  logic [2:0] odiv_code;
  logic [3:0] odiv_value;
  logic [8:0] fb_word;
  logic [6:0] ref_word;

  int checks = 0;
  int fails  = 0;
  logic [23:0] m_shift;
  logic [23:0] m_latch;
  int          m_count;
  logic        m_short;

  serial_cfg_rx i_serial_cfg_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .cap_sel(cap_sel), .duty_mode(duty_mode),
    .aux_sel(aux_sel), .odiv_code(odiv_code), .odiv_value(odiv_value),
    .fb_word(fb_word), .ref_word(ref_word), .fb_illegal(fb_illegal),
    .pll_bypass(pll_bypass), .load_short(load_short)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] exp_od(input logic [2:0] c);
    case (c)
      3'd0: return 4'd10;
      3'd1: return 4'd2;
      3'd2: return 4'd8;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      3'd5: return 4'd7;
      3'd6: return 4'd3;
      default: return 4'd6;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    @(negedge clk);
    chk({tag, " R3 word"}, {8'd0, cap_sel, duty_mode, aux_sel, odiv_code, fb_word, ref_word},
        {8'd0, m_latch});
    chk({tag, " R6 odiv"}, {28'd0, odiv_value}, {28'd0, exp_od(m_latch[18:16])});
    chk({tag, " R7 fb_illegal"}, {31'd0, fb_illegal}, {31'd0, m_latch[15:7] < 9'd4});
    chk({tag, " R8 bypass"}, {31'd0, pll_bypass}, {31'd0, m_latch[6:0] == 7'd0});
    chk({tag, " R9 short"}, {31'd0, load_short}, {31'd0, m_short});
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clks(HALF_BIT);
    ser_clk = 1'b1;
    wait_clks(HALF_BIT);
    ser_clk = 1'b0;
    wait_clks(HALF_BIT);
    m_shift = {m_shift[22:0], b};
    if (m_count < 63) m_count++;
    if (ser_load) m_latch = m_shift;
  endtask

  task automatic send_bits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(val[i]);
  endtask

  task automatic strobe();
    ser_load = 1'b1;
    m_short  = (m_count != 24);
    m_count  = 0;
    m_latch  = m_shift;
    wait_clks(8);
    ser_load = 1'b0;
    wait_clks(8);
  endtask

  task automatic load_word(input logic [23:0] w);
    send_bits({8'd0, w}, 24);
    strobe();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'h5eed_0307));
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    m_shift = 24'h230406; m_latch = 24'h230406; m_count = 0; m_short = 1'b0;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(6);
    check_outputs("R1 reset");
    chk("R1 odiv default 4", {28'd0, odiv_value}, 32'd4);
    chk("R1 fb default 8", {23'd0, fb_word}, 32'd8);

    // R2 R3: a known word, MSB first
    load_word(24'h31_8A_3B);
    check_outputs("R2 known word");
    chk("R3 ref 59", {25'd0, ref_word}, 32'd59);
    chk("R3 fb 276", {23'd0, fb_word}, 32'd276);

    // R4: clocking with strobe low leaves outputs frozen
    w = 24'hC5_0000;
    send_bits({8'd0, w}, 24);
    check_outputs("R4 frozen");
    strobe();
    check_outputs("R4 after strobe");

    // R5: transparent mode, every bit visible
    ser_load = 1'b1;
    m_short  = (m_count != 24);
    m_count  = 0;
    m_latch  = m_shift;
    wait_clks(8);
    for (int i = 0; i < 12; i++) begin
      send_bit(1'(i % 3 == 0));
      check_outputs("R5 transparent");
    end
    ser_load = 1'b0;
    wait_clks(8);

    // R9: short and long bursts
    send_bits(32'h0, 12);
    strobe();
    check_outputs("R9 after 24 total");
    send_bits(32'h5A5A5, 20);
    strobe();
    check_outputs("R9 short 20");
    send_bits(32'h0ABCDE, 23);
    strobe();
    check_outputs("R9 short 23");
    send_bits(32'h1ABCDEF, 25);
    strobe();
    check_outputs("R9 long 25");
    send_bits(32'h2ABCDEF1, 30);
    strobe();
    check_outputs("R9 long 30");
    load_word(24'h123456);
    check_outputs("R9 full clears");

    // R7 R8 boundaries
    for (int f = 0; f < 5; f++) begin
      load_word({8'h00, 9'(f), 7'(f % 2)});
      check_outputs("R7 R8 boundary");
    end

    // R6 every code
    for (int c = 0; c < 8; c++) begin
      load_word({5'b0, 3'(c), 9'd100, 7'd10});
      check_outputs("R6 code");
    end

    // random mix
    for (int k = 0; k < 30; k++) begin
      w = 24'($urandom);
      if ($urandom_range(0, 4) == 0) begin
        send_bits({8'd0, w}, int'($urandom_range(18, 28)));
        strobe();
      end else begin
        load_word(w);
      end
      check_outputs("R3 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule